// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous memory of 32-bit words, organised as four byte lanes. Every control input is sampled at the rising clock edge. Read data passes through an output register, so a read returns its word one edge after the address is taken, and reads can follow each other on every cycle. An access is opened by one of two active-low address strobes and qualified by three chip selects.

The two strobes differ in how they write:

- **Processor strobe.** An access opened here always starts as a read. A write on it needs a second cycle.
- **Controller strobe.** This strobe writes in the cycle it is asserted.

Between strobes, a two-bit wrap-around burst counter moves the address forward (advance low) or holds it (advance high). The counter follows either a linear or an interleaved order, chosen by a static mode input.

The data port is split into `din`, `dout` and a drive-enable `dout_en`. `dout_en` stands in for the three-state control of a shared bus. It is forced low in these cases:

- on a write;
- on a deselect;
- during the first cycle of a read that follows a non-read cycle.

Otherwise the asynchronous active-low output enable gates it.

Top module: `sram_burst_top`

## Requirements
- R1: The part is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. An honoured strobe seen while not selected is a deselect: no byte is written, the burst ends, and `dout_en` is 0 after that edge.
- R2: With `cs1_n`=1 the processor strobe is ignored, so a cycle with only that strobe low behaves as a no-strobe cycle. With `cs1_n`=0 and both strobes low, only the processor strobe is honoured.
- R3: A processor-strobe edge captures `addr` and always performs a read. The write controls and `adv_n` are ignored at that edge. A following no-strobe edge with `adv_n`=1 and active write controls writes `din` at the captured address.
- R4: A controller-strobe edge that is honoured and selected, with active write controls, writes `din` at `addr` on that same edge and ignores `adv_n`. With the write controls inactive it starts a read instead.
- R5: Lane i is `din[8i+7:8i]`. `gwr_n`=0 writes all four lanes. Otherwise, when `bwen_n`=0, lane i is written where `bsel_n[i]`=0. With `gwr_n`=1 and `bwen_n`=1 nothing is written. Lanes that are not written keep their contents.
- R6: A read taken at edge n puts the addressed word on `dout` after edge n+1. Consecutive read edges give consecutive words with no gap.
- R7: `dout_en` is 0 whenever `oe_n`=1. A change of `oe_n` acts on `dout_en` without waiting for a clock.
- R8: `dout_en` goes high only after an edge that follows a read edge. After a deselect or idle state, the cycle following the opening read edge keeps `dout_en` at 0 even with `oe_n`=0.
- R9: After any write edge or deselect edge, `dout_en` is 0 regardless of `oe_n`.
- R10: On a no-strobe edge inside an open burst, `adv_n`=0 moves to the next burst address and `adv_n`=1 repeats the current one. The edge reads or writes according to the write controls.
- R11: The burst order is set by `linear_mode`, and only the two low address bits change. With start bits s and step k, the low bits are (s+k) mod 4 when `linear_mode`=1 and s XOR k when `linear_mode`=0.
- R12: After reset no burst is open, `dout_en` is 0, and no-strobe edges write nothing whatever the write controls and `adv_n` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| linear_mode | input | 1 | Static burst order select: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address, captured on an honoured strobe |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwen_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane byte select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Drive enable for `dout` |

## Verification
Results fall due at fixed offsets:

- A write takes effect on its own edge, and any later read shows it.
- A read taken at edge n puts its word on `dout` and raises `dout_en` only after edge n+1.
- A write or deselect clears `dout_en` right after its own edge.
- `oe_n` acts with no edge at all.

The bench models the memory, the burst counter and a one-deep pending-read stage with plain integers. It updates the model at each rising edge, then compares `dout_en`, and `dout` whenever a drive is expected, at the following falling edge. The bench flips `oe_n` in mid-cycle and samples `dout_en` a fraction of a cycle later, before the next edge.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_DESEL = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  localparam int CNT_W = 2;

  // low address bits of burst step k from start bits s
  function automatic logic [CNT_W-1:0] burst_low(
    input logic [CNT_W-1:0] s,
    input logic [CNT_W-1:0] k,
    input logic             lin
  );
    logic [CNT_W-1:0] r;
    if (lin) r = s + k;
    else     r = s ^ k;
    return r;
  endfunction

endpackage

// File: rtl/sram_access_decode.sv
module sram_access_decode #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              linear_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              gwr_n,
  input  logic              bwen_n,
  input  logic [LANES-1:0]  bsel_n,
  output sram_pkg::op_e     op,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  wr_lanes,
  output logic              burst_act
);
  import sram_pkg::*;

  localparam int HI_W = ADDR_W - CNT_W;

  logic              selected;
  logic              proc_hit;
  logic              ctrl_hit;
  logic [LANES-1:0]  lanes_req;
  logic [ADDR_W-1:0] base_q, base_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic              act_q, act_nx;

  assign burst_act = act_q;

  always_comb begin
    selected = !cs1_n && cs2 && !cs3_n;
    proc_hit = !proc_stb_n && !cs1_n;
    ctrl_hit = !ctrl_stb_n && !proc_hit;
    if (!gwr_n)       lanes_req = '1;
    else if (!bwen_n) lanes_req = ~bsel_n;
    else              lanes_req = '0;
  end

  always_comb begin
    base_nx  = base_q;
    cnt_nx   = cnt_q;
    act_nx   = act_q;
    op       = OP_IDLE;
    wr_lanes = '0;
    acc_addr = {base_q[ADDR_W-1 -: HI_W], burst_low(base_q[CNT_W-1:0], cnt_q, linear_mode)};
    if (proc_hit || ctrl_hit) begin
      if (!selected) begin
        op     = OP_DESEL;
        act_nx = 1'b0;
      end else begin
        act_nx   = 1'b1;
        base_nx  = addr;
        cnt_nx   = '0;
        acc_addr = addr;
        if (ctrl_hit && (|lanes_req)) begin
          op       = OP_WRITE;
          wr_lanes = lanes_req;
        end else begin
          op = OP_READ;
        end
      end
    end else if (act_q) begin
      if (!adv_n) cnt_nx = cnt_q + 1'b1;
      acc_addr = {base_q[ADDR_W-1 -: HI_W], burst_low(base_q[CNT_W-1:0], cnt_nx, linear_mode)};
      if (|lanes_req) begin
        op       = OP_WRITE;
        wr_lanes = lanes_req;
      end else begin
        op = OP_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_nx;
      cnt_q  <= cnt_nx;
      act_q  <= act_nx;
    end
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/sram_read_pipe.sv
module sram_read_pipe #(
  parameter int ADDR_W = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_pkg::op_e     op,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DW-1:0]     rdata,
  output logic [ADDR_W-1:0] stg_addr,
  output logic              stg_rd,
  output logic [DW-1:0]     dout_q,
  output logic              drive_q
);
  import sram_pkg::*;

  logic kill_drive;
  assign kill_drive = (op == OP_WRITE) || (op == OP_DESEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_rd   <= 1'b0;
      stg_addr <= '0;
      dout_q   <= '0;
      drive_q  <= 1'b0;
    end else begin
      stg_rd  <= (op == OP_READ);
      if (op == OP_READ) stg_addr <= acc_addr;
      if (stg_rd) dout_q <= rdata;
      drive_q <= stg_rd && !kill_drive;
    end
  end

endmodule

// File: rtl/sram_burst_top.sv
module sram_burst_top #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    linear_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_stb_n,
  input  logic                    ctrl_stb_n,
  input  logic                    adv_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    gwr_n,
  input  logic                    bwen_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DW = LANES * LANE_W;

  sram_pkg::op_e     op;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  wr_lanes;
  logic              burst_act;
  logic [ADDR_W-1:0] stg_addr;
  logic              stg_rd;
  logic [DW-1:0]     rdata;
  logic [DW-1:0]     dout_q;
  logic              drive_q;

  sram_access_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_decode (
    .clk(clk), .rst_n(rst_n), .linear_mode(linear_mode), .addr(addr),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .gwr_n(gwr_n), .bwen_n(bwen_n), .bsel_n(bsel_n),
    .op(op), .acc_addr(acc_addr), .wr_lanes(wr_lanes), .burst_act(burst_act)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_lanes(wr_lanes), .wr_addr(acc_addr), .wdata(din),
    .rd_addr(stg_addr), .rdata(rdata)
  );

  sram_read_pipe #(.ADDR_W(ADDR_W), .DW(DW)) u_rpipe (
    .clk(clk), .rst_n(rst_n), .op(op), .acc_addr(acc_addr), .rdata(rdata),
    .stg_addr(stg_addr), .stg_rd(stg_rd), .dout_q(dout_q), .drive_q(drive_q)
  );

  assign dout    = dout_q;
  assign dout_en = drive_q && !oe_n;

endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              adv_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              gwr_n,
  input logic              oe_n,
  input logic              dout_en,
  input sram_pkg::op_e     op,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [LANES-1:0]  wr_lanes,
  input logic              burst_act
);
  import sram_pkg::*;

  logic strobe_seen;
  logic no_strobe;
  logic sel;
  assign strobe_seen = (!proc_stb_n && !cs1_n) || !ctrl_stb_n;
  assign no_strobe   = !strobe_seen;
  assign sel         = !cs1_n && cs2 && !cs3_n;

  assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_seen && !sel) |-> (op == OP_DESEL && wr_lanes == '0));

  assert_proc_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && !cs1_n) |-> (wr_lanes == '0));

  assert_global_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE && !gwr_n) |-> (&wr_lanes));

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  assert_first_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_READ) |-> ##2 !dout_en);

  assert_wr_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE || op == OP_DESEL) |=> !dout_en);

  assert_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && burst_act && adv_n) |-> (acc_addr == $past(acc_addr)));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && !burst_act) |-> (op == OP_IDLE && wr_lanes == '0));

endmodule

bind sram_burst_top sram_burst_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (.*);

// File: tb/test_sram_burst_top.sv
`timescale 1ns/1ps
module test_sram_burst_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lin = 1'b1;
  logic [5:0]  addr = '0;
  logic        pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
  logic        cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]  bsel_n = 4'hF;
  logic        oe_n = 1'b0;
  logic [31:0] din = '0;
  wire  [31:0] dout;
  wire         dout_en;

  int vecs = 0;
  int fails = 0;
  string cur_req = "R12";

  always #2 clk = ~clk;

  sram_burst_top i_sram_burst_top (
    .clk(clk), .rst_n(rst_n), .linear_mode(lin), .addr(addr),
    .proc_stb_n(pstb_n), .ctrl_stb_n(cstb_n), .adv_n(adv_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .gwr_n(gw_n), .bwen_n(bwe_n), .bsel_n(bsel_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // reference model state
  logic [31:0] mm [64];
  bit          m_act, m_pend, m_drive;
  int          m_base, m_cnt, m_paddr;
  logic [31:0] m_dout;

  function automatic logic [31:0] pat(int a);
    return 32'hA500_0000 ^ (a * 32'h0103_0507);
  endfunction

  function automatic int burst_word();
    int lo, k;
    lo = m_base % 4;
    if (lin) k = (lo + m_cnt) % 4;
    else     k = lo ^ m_cnt;
    return m_base - lo + k;
  endfunction

  task automatic model_reset();
    m_act = 0; m_pend = 0; m_drive = 0; m_cnt = 0; m_base = 0;
  endtask

  // kinds: 0 idle, 1 deselect, 2 read, 3 write
  task automatic model_step();
    bit ph, ch, sel;
    int ln, a, kind;
    ph  = !pstb_n && !cs1_n;
    ch  = !cstb_n && !ph;
    sel = !cs1_n && cs2 && !cs3_n;
    ln  = !gw_n ? 15 : (!bwe_n ? int'(~bsel_n & 4'hF) : 0);
    kind = 0; a = 0;
    if (ph || ch) begin
      if (!sel) begin kind = 1; m_act = 0; end
      else begin
        m_act = 1; m_base = addr; m_cnt = 0; a = addr;
        kind = (ch && ln != 0) ? 3 : 2;
      end
    end else if (m_act) begin
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      a = burst_word();
      kind = (ln != 0) ? 3 : 2;
    end
    m_drive = m_pend && !(kind == 1 || kind == 3);
    if (m_pend) m_dout = mm[m_paddr];
    if (kind == 3)
      for (int l = 0; l < 4; l++)
        if (ln[l]) mm[a][8*l +: 8] = din[8*l +: 8];
    m_pend = (kind == 2);
    m_paddr = a;
  endtask

  task automatic compare();
    bit ee;
    ee = m_drive && !oe_n;
    vecs++;
    if (dout_en !== ee) begin
      fails++;
      $display("FAIL %s dout_en actual=%b expected=%b at %0t", cur_req, dout_en, ee, $time);
    end else if (ee && dout !== m_dout) begin
      fails++;
      $display("FAIL %s dout actual=%h expected=%h at %0t", cur_req, dout, m_dout, $time);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    pstb_n = 1; cstb_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = 4'hF;
    cs1_n = 0; cs2 = 1; cs3_n = 0;
  endtask

  task automatic ctrl_wr(int a, logic [31:0] d, logic g, logic b, logic [3:0] s);
    quiet(); cstb_n = 0; addr = 6'(a); din = d; gw_n = g; bwe_n = b; bsel_n = s;
    tick(); quiet();
  endtask

  task automatic ctrl_rd(int a);
    quiet(); cstb_n = 0; addr = 6'(a); tick(); quiet();
  endtask

  task automatic proc_rd(int a);
    quiet(); pstb_n = 0; addr = 6'(a); tick(); quiet();
  endtask

  task automatic deselect();
    quiet(); cstb_n = 0; cs2 = 0; tick(); quiet();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_bit("R12", dout_en, 1'b0);

    // R4 R5: fill every word by controller-strobe global writes
    cur_req = "R4";
    for (int a = 0; a < 64; a++) ctrl_wr(a, pat(a), 1'b0, 1'b1, 4'hF);
    deselect();

    // R6: back-to-back reads, then a consecutive read of all words
    cur_req = "R6";
    for (int a = 0; a < 64; a++) ctrl_rd(a);
    tick(); tick();

    // R7: output enable acts without a clock edge
    cur_req = "R7";
    ctrl_rd(5); ctrl_rd(6);
    check_bit("R7", dout_en, 1'b1);
    oe_n = 1; #0.5;
    check_bit("R7", dout_en, 1'b0);
    oe_n = 0; #0.5;
    check_bit("R7", dout_en, 1'b1);
    tick();

    // R8: first read after deselect keeps drive off for one cycle
    cur_req = "R8";
    deselect();
    ctrl_rd(9);
    check_bit("R8", dout_en, 1'b0);
    tick();
    check_bit("R8", dout_en, 1'b1);

    // R5: byte-lane masks on controller writes
    cur_req = "R5";
    ctrl_wr(10, 32'h1122_3344, 1'b1, 1'b0, 4'b1110);
    ctrl_wr(11, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'b0101);
    ctrl_wr(12, 32'hCAFE_F00D, 1'b1, 1'b1, 4'b0000);
    ctrl_wr(13, 32'h0BAD_C0DE, 1'b0, 1'b1, 4'b1111);
    ctrl_wr(14, 32'h7777_7777, 1'b1, 1'b0, 4'b1111);
    for (int a = 10; a < 15; a++) ctrl_rd(a);
    tick();

    // R9: write right after a read: drive forced off
    cur_req = "R9";
    ctrl_rd(20);
    ctrl_wr(21, 32'h5555_AAAA, 1'b0, 1'b1, 4'hF);
    check_bit("R9", dout_en, 1'b0);
    ctrl_rd(21); tick();

    // R3: processor strobe with write controls reads; two-cycle write after
    cur_req = "R3";
    quiet(); pstb_n = 0; addr = 6'd30; gw_n = 0; din = 32'hFFFF_0000; adv_n = 0; tick();
    quiet(); gw_n = 0; adv_n = 1; din = 32'h3030_3030; tick();
    quiet(); tick();
    ctrl_rd(30); ctrl_rd(31); tick();

    // R2: both strobes low: processor wins, no write
    cur_req = "R2";
    quiet(); pstb_n = 0; cstb_n = 0; addr = 6'd33; gw_n = 0; din = 32'h0; tick();
    quiet(); tick();
    ctrl_rd(33); tick();
    // R2: cs1_n high ignores processor strobe: burst continues
    ctrl_rd(40);
    quiet(); pstb_n = 0; cs1_n = 1; adv_n = 0; addr = 6'd2; tick();
    quiet(); tick(); tick();

    // R1: deselect through cs2 and cs3_n with write controls active
    cur_req = "R1";
    quiet(); cstb_n = 0; cs2 = 0; addr = 6'd44; gw_n = 0; din = 32'h0; tick();
    check_bit("R1", dout_en, 1'b0);
    quiet(); pstb_n = 0; cs3_n = 1; addr = 6'd45; tick();
    quiet(); gw_n = 0; tick();
    ctrl_rd(44); ctrl_rd(45); ctrl_rd(0); tick();

    // R10 R11: linear read burst with continue and suspend
    cur_req = "R11";
    lin = 1;
    ctrl_rd(50);
    quiet(); adv_n = 0; tick(); tick();
    quiet(); adv_n = 1; tick();
    quiet(); adv_n = 0; tick(); tick(); tick();
    deselect();
    // interleaved order
    lin = 0;
    ctrl_rd(55);
    quiet(); adv_n = 0; tick(); tick(); tick(); tick();
    deselect();

    // R10: write burst continue and suspend
    cur_req = "R10";
    ctrl_wr(58, 32'hA0A0_0001, 1'b0, 1'b1, 4'hF);
    quiet(); gw_n = 0; adv_n = 0; din = 32'hA0A0_0002; tick();
    quiet(); gw_n = 0; adv_n = 1; din = 32'hA0A0_0003; tick();
    quiet(); bwe_n = 0; bsel_n = 4'b0011; adv_n = 0; din = 32'hB1B2_B3B4; tick();
    deselect();
    lin = 1;
    ctrl_rd(56);
    quiet(); adv_n = 0; tick(); tick(); tick();
    tick();
    deselect();

    // R12: reset, then no-strobe cycles with write controls do nothing
    cur_req = "R12";
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    check_bit("R12", dout_en, 1'b0);
    quiet(); gw_n = 0; adv_n = 0; din = 32'h0;
    repeat (4) tick();
    quiet();
    for (int a = 0; a < 4; a++) ctrl_rd(a);
    tick();

    // R6: final full sweep via linear bursts
    cur_req = "R6";
    lin = 1;
    for (int a = 0; a < 64; a += 4) begin
      ctrl_rd(a);
      quiet(); adv_n = 0; tick(); tick(); tick();
    end
    tick(); tick();

    report();
    $finish;
  end

endmodule